// File: doc/BRIEF.md
# Programmable Frequency Generator Bank

This block turns a small set of source tick strobes into six slower tick streams, one per channel. Every source arrives as a one-cycle strobe in the system clock domain. Each channel counts the strobes of the source it has picked and emits a one-cycle output tick once per programmed period. Alongside the tick it drives a square-wave enable that is high for the first half of each period. No second clock domain is involved: downstream logic uses the ticks as clock enables.

Two 32-bit control words set up the channels, three channels per word, each in a 10-bit field. A mode input, captured once after reset, picks how a field is read. In the basic reading, a field bit picks one of two sources and a second bit enables the channel, and divisors are always even. In the extended reading, a two-bit code picks one of three sources, with code zero meaning off, and a per-word scale bit switches the divisor to steps of one.

Changes to a running channel's divider or source are deferred to the end of the current output period, so no shortened period appears on the output. Disabling a channel is immediate and clears its counter.

Top module: `fgen_bank`

## Requirements
- R1: After reset both control words read as zero and every `ch_tick` and `ch_sq` bit is low.
- R2: A read returns the last value written to the selected word, masked. Bit 31 always reads 0. In basic mode bit 30 also reads 0. In extended mode bit 30 reads as written.
- R3: Channel c lives in word c/3 at bit offset 10*(c mod 3). In basic mode, field bit 1 enables the channel and field bit 0 picks source 0 (value 0) or source 1 (value 1). Strobes on a source that is not selected have no effect on the channel.
- R4: Field bits [9:2] hold a code N. In basic mode, or in extended mode with the word's bit 30 clear, a running channel emits one output tick per 2*(N+1) strobes of its source.
- R5: In extended mode with bit 30 of the word set, the period is N+1 strobes. With N=0, every source strobe produces an output tick, including strobes on consecutive cycles.
- R6: In extended mode, field bits [1:0] equal to 1, 2 or 3 select source 0, 1 or 2. The value 0 disables the channel.
- R7: A disabled channel holds `ch_tick` and `ch_sq` low and clears its count. After it is enabled again, its first tick comes on exactly the D-th source strobe, where D is its period.
- R8: While a channel runs, `ch_sq` is high after 0 to ceil(D/2)-1 strobes of the current period and low for the rest of the period.
- R9: A write that changes the divider code or the source of a running channel leaves the current period untouched: that period ends after the old count on the old source, and the new settings apply from the next period.
- R10: An output tick is one clock wide. It appears in the cycle after the clock edge that samples the period-completing source strobe.
- R11: The mode input is sampled on the first clock after reset is released. Later changes to it alter neither field decoding nor read masking.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_ext | input | 1 | 1 selects the extended field reading; sampled once after reset |
| src_tick | input | NSRC | One-cycle source strobes |
| wr_en | input | 1 | Write strobe for a control word |
| wr_addr | input | ADDR_W | Word selected for the write |
| wr_data | input | 32 | Write data |
| rd_addr | input | ADDR_W | Word selected for the read |
| rd_data | output | 32 | Masked contents of the selected word |
| ch_tick | output | NREG*CH_PER_REG | One-cycle output tick per channel |
| ch_sq | output | NREG*CH_PER_REG | Square-wave enable per channel |

## Verification
The division is exercised with isolated strobes that have idle cycles between them and with back-to-back strobe bursts. The bursts separate a divide-by-one channel that ticks every cycle from one that drops pulses or stretches them. Strobes are sent on sources that a channel has not selected, which shows whether the source multiplexer picks the right line under each field reading. Sending the same codes after a reset in the other mode distinguishes the two readings. Mid-period rewrites of the divider and source, followed by counting the strobes to the next tick, separate deferred updates from immediate ones. A mid-period disable, followed by a re-enable, shows whether the count restarts from zero.

// File: rtl/fgen_pkg.sv
package fgen_pkg;

  localparam int FIELD_W   = 10;
  localparam int DIV_W     = 8;
  localparam int SEL_W     = 2;
  localparam int DATA_W    = 32;
  localparam int SCALE_POS = 30;
  localparam int PER_W     = DIV_W + 2;

  typedef struct packed {
    logic             en;
    logic [SEL_W-1:0] src;
    logic [DIV_W-1:0] ncode;
    logic             scale;
  } chan_cfg_t;

  // interpret one channel field under the chosen mode
  function automatic chan_cfg_t decode_field(input logic [FIELD_W-1:0] f,
                                             input logic ext,
                                             input logic scale);
    chan_cfg_t c;
    c.ncode = f[FIELD_W-1:2];
    c.scale = ext & scale;
    if (ext) begin
      c.en  = (f[1:0] != 2'd0);
      c.src = f[1:0] - 2'd1;
    end else begin
      c.en  = f[1];
      c.src = {1'b0, f[0]};
    end
    return c;
  endfunction

  // number of source strobes in one output period
  function automatic logic [PER_W-1:0] period_of(input chan_cfg_t c);
    logic [PER_W-1:0] base;
    base = PER_W'(c.ncode) + 1'b1;
    return c.scale ? base : (base << 1);
  endfunction

endpackage

// File: rtl/fgen_rst_sync.sv
module fgen_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];

endmodule

// File: rtl/fgen_ctrl_regs.sv
module fgen_ctrl_regs
  import fgen_pkg::*;
#(
  parameter int NREG   = 2,
  parameter int ADDR_W = 1
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            mode_in,
  input  logic                            wr_en,
  input  logic [ADDR_W-1:0]               wr_addr,
  input  logic [DATA_W-1:0]               wr_data,
  input  logic [ADDR_W-1:0]               rd_addr,
  output logic [DATA_W-1:0]               rd_data,
  output logic [NREG-1:0][SCALE_POS:0]    ctrl_o,
  output logic                            mode_o,
  output logic                            lock_o
);

  localparam logic [DATA_W-1:0] KEEP_BASIC =
    {{(DATA_W-SCALE_POS){1'b0}}, {SCALE_POS{1'b1}}};
  localparam logic [DATA_W-1:0] KEEP_EXT =
    {{(DATA_W-SCALE_POS-1){1'b0}}, {(SCALE_POS+1){1'b1}}};

  logic [NREG-1:0][DATA_W-1:0] ctrl_q, ctrl_n;
  logic                        mode_q, mode_n;
  logic                        lock_q;
  logic                        mode_eff;
  logic [DATA_W-1:0]           keep;

  always_comb begin
    mode_eff = lock_q ? mode_q : mode_in;
    keep     = mode_eff ? KEEP_EXT : KEEP_BASIC;
    mode_n   = mode_eff;
    ctrl_n   = ctrl_q;
    if (wr_en && (int'(wr_addr) < NREG))
      ctrl_n[wr_addr] = wr_data & keep;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      mode_q <= 1'b0;
      lock_q <= 1'b0;
    end else begin
      ctrl_q <= ctrl_n;
      mode_q <= mode_n;
      lock_q <= 1'b1;
    end
  end

  always_comb begin
    rd_data = '0;
    if (int'(rd_addr) < NREG) rd_data = ctrl_q[rd_addr];
  end

  for (genvar r = 0; r < NREG; r++) begin : g_out
    assign ctrl_o[r] = ctrl_q[r][SCALE_POS:0];
  end

  assign mode_o = mode_q;
  assign lock_o = lock_q;

endmodule

// File: rtl/fgen_channel.sv
module fgen_channel
  import fgen_pkg::*;
#(
  parameter int NSRC = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [FIELD_W-1:0] field_i,
  input  logic               ext_i,
  input  logic               scale_i,
  input  logic [NSRC-1:0]    src_tick_i,
  output logic               tick_o,
  output logic               sq_o,
  output logic               run_o
);

  localparam int CNT_W = PER_W - 1;

  chan_cfg_t        fld_cfg, eff_cfg, act_q, act_n;
  logic [PER_W-1:0] eff_per, act_per, act_half;
  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic             run_q, run_n;
  logic             tick_q, tick_n;
  logic             sel_tick, wrap;

  // next-state: settings reach the counter only at a period end
  always_comb begin
    fld_cfg  = decode_field(field_i, ext_i, scale_i);
    eff_cfg  = run_q ? act_q : fld_cfg;
    eff_per  = period_of(eff_cfg);
    sel_tick = 1'b0;
    for (int s = 0; s < NSRC; s++)
      if (int'(eff_cfg.src) == s) sel_tick = src_tick_i[s];
    wrap = sel_tick && ({1'b0, cnt_q} == (eff_per - 1'b1));

    run_n  = run_q;
    act_n  = act_q;
    cnt_n  = cnt_q;
    tick_n = 1'b0;
    if (!fld_cfg.en) begin
      run_n = 1'b0;
      cnt_n = '0;
    end else begin
      run_n  = 1'b1;
      tick_n = wrap;
      if (!run_q || wrap) act_n = fld_cfg;
      if (wrap)          cnt_n = '0;
      else if (sel_tick) cnt_n = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      act_q  <= '0;
      cnt_q  <= '0;
      tick_q <= 1'b0;
    end else begin
      run_q  <= run_n;
      act_q  <= act_n;
      cnt_q  <= cnt_n;
      tick_q <= tick_n;
    end
  end

  always_comb begin
    act_per  = period_of(act_q);
    act_half = act_per - (act_per >> 1);
  end

  assign sq_o   = run_q && act_q.en && ({1'b0, cnt_q} < act_half);
  assign tick_o = tick_q;
  assign run_o  = run_q;

endmodule

// File: rtl/fgen_bank.sv
module fgen_bank
  import fgen_pkg::*;
#(
  parameter int NREG       = 2,
  parameter int CH_PER_REG = 3,
  parameter int NSRC       = 3,
  parameter int ADDR_W     = 1
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         mode_ext,
  input  logic [NSRC-1:0]              src_tick,
  input  logic                         wr_en,
  input  logic [ADDR_W-1:0]            wr_addr,
  input  logic [DATA_W-1:0]            wr_data,
  input  logic [ADDR_W-1:0]            rd_addr,
  output logic [DATA_W-1:0]            rd_data,
  output logic [NREG*CH_PER_REG-1:0]   ch_tick,
  output logic [NREG*CH_PER_REG-1:0]   ch_sq
);

  localparam int NCH = NREG * CH_PER_REG;

  logic                         rst_sync_n;
  logic [NREG-1:0][SCALE_POS:0] ctrl;
  logic                         mode_q;
  logic                         mode_lock;
  logic [NCH-1:0]               chan_run;

  fgen_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  fgen_ctrl_regs #(.NREG(NREG), .ADDR_W(ADDR_W)) u_regs (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .mode_in (mode_ext),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .rd_addr (rd_addr),
    .rd_data (rd_data),
    .ctrl_o  (ctrl),
    .mode_o  (mode_q),
    .lock_o  (mode_lock)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    localparam int REG  = c / CH_PER_REG;
    localparam int SLOT = c % CH_PER_REG;
    fgen_channel #(.NSRC(NSRC)) u_ch (
      .clk        (clk),
      .rst_n      (rst_sync_n),
      .field_i    (ctrl[REG][SLOT*FIELD_W +: FIELD_W]),
      .ext_i      (mode_q),
      .scale_i    (ctrl[REG][SCALE_POS]),
      .src_tick_i (src_tick),
      .tick_o     (ch_tick[c]),
      .sq_o       (ch_sq[c]),
      .run_o      (chan_run[c])
    );
  end

endmodule

// File: rtl/fgen_bank_chk.sv
module fgen_bank_chk #(
  parameter int NCH  = 6,
  parameter int NSRC = 3
) (
  input logic            clk,
  input logic            rst_n,
  input logic [NSRC-1:0] src_tick,
  input logic [NCH-1:0]  ch_tick,
  input logic [NCH-1:0]  ch_sq,
  input logic [NCH-1:0]  chan_run,
  input logic [31:0]     rd_data,
  input logic            mode_q,
  input logic            mode_lock
);

  for (genvar i = 0; i < NCH; i++) begin : g_a
    // R7: an idle channel is silent on both outputs
    p_idle_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !chan_run[i] |-> (!ch_tick[i] && !ch_sq[i]));
    // R10: every output tick follows a sampled source strobe
    p_tick_after_src_r10: assert property (@(posedge clk) disable iff (!rst_n)
      ch_tick[i] |-> $past(|src_tick));
  end

  // R2: the top bit never reads back
  p_top_bit_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[31] == 1'b0);

  // R2: no scale bit in basic mode
  p_basic_no_scale_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_lock && !mode_q) |-> !rd_data[30]);

  // R11: the captured mode never moves
  p_mode_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    mode_lock |=> (mode_lock && $stable(mode_q)));

endmodule

bind fgen_bank fgen_bank_chk #(.NCH(NREG*CH_PER_REG), .NSRC(NSRC)) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .src_tick  (src_tick),
  .ch_tick   (ch_tick),
  .ch_sq     (ch_sq),
  .chan_run  (chan_run),
  .rd_data   (rd_data),
  .mode_q    (mode_q),
  .mode_lock (mode_lock)
);

// File: tb/fgen_bank_test.sv
module fgen_bank_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mode_ext = 1'b0;
  logic [2:0]  src_tick = '0;
  logic        wr_en = 1'b0;
  logic        wr_addr = 1'b0;
  logic [31:0] wr_data = '0;
  logic        rd_addr = 1'b0;
  logic [31:0] rd_data;
  logic [5:0]  ch_tick, ch_sq;

  always #10 clk = ~clk;

  fgen_bank uut (
    .clk(clk), .rst_n(rst_n), .mode_ext(mode_ext), .src_tick(src_tick),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .ch_tick(ch_tick), .ch_sq(ch_sq)
  );

  int    total = 0, bad = 0, cyc = 0;
  bit    mon_on = 1'b0, finished = 1'b0;
  string cur_req = "R1";
  int    expq [6][$];
  int    m_cnt [6], m_d [6], m_pd [6], m_src [6], m_psrc [6];
  bit    m_en [6];
  logic [31:0] shadow [2];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp_v);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp_v);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  // monitor: pops expected tick cycles as the design produces ticks
  always @(negedge clk) begin
    if (mon_on) begin
      for (int c = 0; c < 6; c++) begin
        if (expq[c].size() > 0 && expq[c][0] < cyc) begin
          check(1'b0, cur_req, $sformatf("missing tick ch%0d", c), cyc, expq[c][0]);
          void'(expq[c].pop_front());
        end
        if (ch_tick[c]) begin
          if (expq[c].size() == 0)
            check(1'b0, cur_req, $sformatf("unexpected tick ch%0d", c), 1, 0);
          else begin
            int e;
            e = expq[c].pop_front();
            check(e == cyc, cur_req, $sformatf("tick cycle ch%0d", c), cyc, e);
          end
        end
      end
    end
  end

  // reference model update for one sampled strobe on source s
  task automatic model_tick(input int s);
    for (int c = 0; c < 6; c++) begin
      if (m_en[c] && m_src[c] == s) begin
        m_cnt[c]++;
        if (m_cnt[c] == m_d[c]) begin
          expq[c].push_back(cyc);
          m_cnt[c] = 0;
          m_d[c]   = m_pd[c];
          m_src[c] = m_psrc[c];
        end
      end
    end
  endtask

  task automatic pulse(input int s, input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); src_tick[s] = 1'b1;
      @(posedge clk); #1; model_tick(s);
      @(negedge clk); src_tick[s] = 1'b0;
      @(negedge clk);
    end
  endtask

  task automatic burst(input int s, input int n);
    @(negedge clk); src_tick[s] = 1'b1;
    for (int k = 0; k < n; k++) begin
      @(posedge clk); #1; model_tick(s);
    end
    @(negedge clk); src_tick[s] = 1'b0;
    @(negedge clk);
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a[0]; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd_check(input int a, input logic [31:0] exp_v, input string req);
    @(negedge clk); rd_addr = a[0]; #1;
    check(rd_data == exp_v, req, $sformatf("readback word%0d", a), rd_data, exp_v);
  endtask

  task automatic drain(input string req);
    repeat (4) @(negedge clk);
    for (int c = 0; c < 6; c++)
      check(expq[c].size() == 0, req, $sformatf("pending ticks ch%0d", c), expq[c].size(), 0);
  endtask

  // field: basic {N, en, src}; extended {N, src+1 or 0}; word bit 30 = scale
  task automatic set_ch(input int c, input bit en, input int src, input int nc,
                        input bit ext, input bit scl);
    int r, slot, d;
    logic [9:0] f;
    r = c / 3; slot = c % 3;
    f[9:2] = nc[7:0];
    f[1:0] = ext ? (en ? 2'(src + 1) : 2'd0) : {en, src[0]};
    shadow[r][slot*10 +: 10] = f;
    shadow[r][30] = scl;
    d = (ext && scl) ? nc + 1 : 2 * (nc + 1);
    if (!en) begin
      m_en[c] = 1'b0; m_cnt[c] = 0;
    end else if (!m_en[c]) begin
      m_en[c] = 1'b1; m_cnt[c] = 0; m_d[c] = d; m_pd[c] = d;
      m_src[c] = src; m_psrc[c] = src;
    end else begin
      m_pd[c] = d; m_psrc[c] = src;
    end
    wr(r, shadow[r]);
    repeat (2) @(negedge clk);
  endtask

  task automatic do_reset(input bit mode);
    mon_on = 1'b0;
    rst_n = 1'b0; mode_ext = mode;
    for (int c = 0; c < 6; c++) begin
      expq[c].delete(); m_en[c] = 1'b0; m_cnt[c] = 0;
      m_d[c] = 2; m_pd[c] = 2; m_src[c] = 0; m_psrc[c] = 0;
    end
    shadow[0] = '0; shadow[1] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    mon_on = 1'b1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    check(1'b0, cur_req, "watchdog expired", cyc, 0);
    finish_run();
  end

  initial begin
    // ---------------- basic mode ----------------
    do_reset(1'b0);
    cur_req = "R1";
    rd_check(0, 32'h0, "R1");
    rd_check(1, 32'h0, "R1");
    check(ch_tick == 6'h0, "R1", "ticks after reset", ch_tick, 0);
    check(ch_sq == 6'h0, "R1", "square after reset", ch_sq, 0);

    cur_req = "R2";
    wr(1, 32'hFFFF_FFFF);
    rd_check(1, 32'h3FFF_FFFF, "R2");
    rd_check(0, 32'h0, "R2");
    wr(1, 32'h0);
    repeat (2) @(negedge clk);
    rd_check(1, 32'h0, "R2");

    cur_req = "R4";                      // ch1, source 1, N=1 -> 4 strobes
    set_ch(1, 1'b1, 1, 1, 1'b0, 1'b0);
    pulse(1, 8);
    cur_req = "R3";                      // strobes on source 0 ignored by ch1
    pulse(0, 3);
    drain("R3");
    check(m_cnt[1] == 0, "R3", "ch1 model count", m_cnt[1], 0);

    cur_req = "R3";                      // ch5 (word1, offset 20) on source 0, D=2
    set_ch(5, 1'b1, 0, 0, 1'b0, 1'b0);
    pulse(0, 4);
    drain("R3");

    cur_req = "R8";                      // square wave, D=4
    set_ch(1, 1'b0, 1, 1, 1'b0, 1'b0);
    set_ch(1, 1'b1, 1, 1, 1'b0, 1'b0);
    check(ch_sq[1] == 1'b1, "R8", "sq after 0 strobes", ch_sq[1], 1);
    pulse(1, 1); check(ch_sq[1] == 1'b1, "R8", "sq after 1 strobe", ch_sq[1], 1);
    pulse(1, 1); check(ch_sq[1] == 1'b0, "R8", "sq after 2 strobes", ch_sq[1], 0);
    pulse(1, 1); check(ch_sq[1] == 1'b0, "R8", "sq after 3 strobes", ch_sq[1], 0);
    pulse(1, 1); check(ch_sq[1] == 1'b1, "R8", "sq after 4 strobes", ch_sq[1], 1);
    drain("R8");

    cur_req = "R9";                      // ch4: D=4 on src0, then D=2 on src1 mid-period
    set_ch(4, 1'b1, 0, 1, 1'b0, 1'b0);
    pulse(0, 2);
    set_ch(4, 1'b1, 1, 0, 1'b0, 1'b0);
    pulse(0, 2);                         // old period ends on old source
    pulse(1, 2);                         // new settings: tick after 2 on src1
    pulse(0, 2);                         // ch4 ignores src0 now
    drain("R9");

    cur_req = "R7";                      // disable mid-period, then restart
    pulse(1, 2);
    set_ch(1, 1'b0, 1, 1, 1'b0, 1'b0);
    check(ch_sq[1] == 1'b0, "R7", "sq while disabled", ch_sq[1], 0);
    pulse(1, 3);
    check(ch_sq[1] == 1'b0, "R7", "sq stays low", ch_sq[1], 0);
    set_ch(1, 1'b1, 1, 1, 1'b0, 1'b0);
    check(ch_sq[1] == 1'b1, "R7", "sq after restart", ch_sq[1], 1);
    pulse(1, 4);
    drain("R7");

    // ---------------- extended mode ----------------
    do_reset(1'b1);
    cur_req = "R11";
    mode_ext = 1'b0;                     // must be ignored from now on
    repeat (3) @(negedge clk);
    wr(0, 32'hFFFF_FFFF);
    rd_check(0, 32'h7FFF_FFFF, "R11");
    wr(0, 32'h0);
    repeat (2) @(negedge clk);

    cur_req = "R6";                      // ch0 code 3 -> source 2, scale, N=2 -> D=3
    set_ch(0, 1'b1, 2, 2, 1'b1, 1'b1);
    pulse(2, 6);
    pulse(0, 2);
    pulse(1, 2);
    drain("R6");

    cur_req = "R5";                      // ch2 source 0, N=0 with scale -> every strobe
    set_ch(2, 1'b1, 0, 0, 1'b1, 1'b1);
    check(ch_sq[2] == 1'b1, "R5", "sq with D=1", ch_sq[2], 1);
    burst(0, 5);
    drain("R5");

    cur_req = "R6";                      // code 0 disables ch0
    set_ch(0, 1'b0, 2, 2, 1'b1, 1'b1);
    pulse(2, 3);
    check(ch_sq[0] == 1'b0, "R6", "sq with code 0", ch_sq[0], 0);
    drain("R6");

    cur_req = "R11";                     // ch3 code 2 -> source 1, scale clear -> D=2
    set_ch(3, 1'b1, 1, 0, 1'b1, 1'b0);
    rd_check(1, shadow[1], "R11");
    pulse(1, 4);
    pulse(0, 2);                         // ch2 ticks, ch3 silent
    drain("R11");

    finish_run();
  end

endmodule